// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Unit

The unit watches a demodulated infrared receiver line that idles high. It measures every symbol it sees, where a symbol is one low (pulse) phase followed by one high (space) phase, and packs the two durations into one word. It keeps the words in a small FIFO that software drains through a word-addressed register port. The input goes through a two-flop synchronizer and a majority-free "all samples agree" glitch filter before any edge is taken.

Durations are counted in units of `(prescaler + 1) * UNIT_TICKS` clock cycles. With the prescaler set to the clock frequency in MHz minus one and the default `UNIT_TICKS = 10`, one unit is 10 µs. A space that grows until low plus high reaches a programmed maximum width ends the stream. The unit then stores the cut-off symbol and flags a timeout. Three interrupt sources drive one `irq_o`: the fill level, the end-of-stream timeout, and overflow. Each source can be masked.

Top module: `irc_raw_capture`

## Requirements
- R1: After reset, config (0x04) reads 0x3E800080 (max width 0x3E80 in bits 31:16, symbol format 0 in 15:14, level-minus-one 0 in 13:8, raw bit 7 set, prescaler 0 in 6:0). The symbol count (0x20) and status (0x2C) read 0, and `irq_o` is low.
- R2: Writing 1 to bit 0 of enable (0x00) makes busy (0x1C) read 1 for the next `FILT_LEN+3` cycles. After that it reads 0.
- R3: No symbol is captured until any value is written to start (0x34) while enabled. Writing 0 to enable stops capture, and a new start write is needed after re-enabling.
- R4: Durations count in units of `(cfg[6:0]+1)*UNIT_TICKS` cycles. A stored word has the low duration in bits 15:0 and the high duration in bits 31:16. Config reads back what was written.
- R5: A symbol's high phase is closed by the next falling edge, and that symbol is stored at that edge.
- R6: When low plus high reaches max width (cfg[31:16]), the high phase stops. The symbol is stored with high = max width − low, and the sticky timeout status (bit 9) sets.
- R7: Count (0x20) returns the number of stored words. Each read of data (0x24) returns the oldest word and removes it. A read of data while empty returns 0.
- R8: Receive status (bit 8) is high while enabled and the count is at least cfg[13:8]+1.
- R9: A symbol completed while the FIFO is full is dropped and sets the sticky overflow status (bit 10). The stored words stay until read.
- R10: Mask (0x28) bits 8, 9 and 10 mask receive, timeout and overflow (1 = masked, so 0 enables all). Status bits 24..26 are raw status AND NOT mask, and `irq_o` is the OR of those three bits.
- R11: Writing 1 to clear (0x30) bit 17 clears timeout and bit 18 clears overflow. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated infrared line, idle high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a read of data pops) |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, same cycle |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench targets the timeout cut, where a wrong sum or off-by-one comparison would store a high duration other than max width minus low. It fills the FIFO past capacity: a design that flushed on overflow would return no data, and one that overwrote would return a later word at the head. It checks masking, where the raw bit must stay visible while the masked copy and `irq_o` stay low. It also checks that edges before the start write, or after a disable, leave the count at zero.

// File: rtl/irc_pkg.sv
package irc_pkg;

   localparam logic [5:0] A_ENABLE = 6'h00;
   localparam logic [5:0] A_CONFIG = 6'h04;
   localparam logic [5:0] A_BUSY   = 6'h1C;
   localparam logic [5:0] A_COUNT  = 6'h20;
   localparam logic [5:0] A_DATA   = 6'h24;
   localparam logic [5:0] A_MASK   = 6'h28;
   localparam logic [5:0] A_STATUS = 6'h2C;
   localparam logic [5:0] A_CLEAR  = 6'h30;
   localparam logic [5:0] A_START  = 6'h34;

   typedef enum logic [2:0] {
      ST_OFF, ST_ARM, ST_IDLE, ST_LOW, ST_HIGH
   } meter_st_e;

   typedef struct packed {
      logic [15:0] max_w;
      logic [1:0]  fmt;
      logic [5:0]  lvl_m1;
      logic        raw;
      logic [6:0]  presc;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{max_w: 16'h3E80, fmt: 2'd0, lvl_m1: 6'd0,
                                  raw: 1'b1, presc: 7'd0};

endpackage

// File: rtl/irc_line_filter.sv
module irc_line_filter #(
   parameter int unsigned FILT_LEN = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic line_o
);

   logic [1:0] sync_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= 2'b11;
      else         sync_q <= {sync_q[0], line_i};
   end

   generate
      if (FILT_LEN == 0) begin : g_bypass
         assign line_o = sync_q[1];
      end else begin : g_filter
         logic [FILT_LEN-1:0] hist_q;
         logic                out_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hist_q <= '1;
               out_q  <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
               if (&hist_q)       out_q <= 1'b1;
               else if (~|hist_q) out_q <= 1'b0;
            end
         end
         assign line_o = out_q;
         if (FILT_LEN < 2) begin : g_len_chk
            $error("FILT_LEN must be 0 or at least 2");
         end
      end
   endgenerate

endmodule

// File: rtl/irc_sym_meter.sv
module irc_sym_meter
   import irc_pkg::*;
#(
   parameter int unsigned DUR_W      = 16,
   parameter int unsigned PRE_W      = 7,
   parameter int unsigned UNIT_TICKS = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             line_i,
   input  logic [PRE_W-1:0] presc_i,
   input  logic [DUR_W-1:0] max_w_i,
   output logic             sym_valid_o,
   output logic [DUR_W-1:0] sym_lo_o,
   output logic [DUR_W-1:0] sym_hi_o,
   output logic             tmo_o
);

   localparam int unsigned TW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;

   if (UNIT_TICKS < 1) begin : g_ut_chk
      $error("UNIT_TICKS must be at least 1");
   end

   meter_st_e        st_q, st_d;
   logic             line_q;
   logic [PRE_W-1:0] pre_q;
   logic [TW-1:0]    dec_q;
   logic [DUR_W-1:0] lo_q, hi_q;
   logic             fall, rise, tick, over, restart, push;
   logic [DUR_W:0]   sum;

   function automatic logic [DUR_W-1:0] sat_inc(input logic [DUR_W-1:0] v);
      return (&v) ? v : v + 1'b1;
   endfunction

   assign fall = line_q & ~line_i;
   assign rise = ~line_q & line_i;
   assign tick = (pre_q == presc_i) && (dec_q == TW'(UNIT_TICKS - 1));
   assign sum  = {1'b0, lo_q} + {1'b0, hi_q};
   assign over = sum >= {1'b0, max_w_i};

   always_comb begin
      st_d    = st_q;
      restart = 1'b0;
      push    = 1'b0;
      tmo_o   = 1'b0;
      unique case (st_q)
         ST_OFF:  st_d = ST_ARM;
         ST_ARM:  if (line_i) st_d = ST_IDLE;
         ST_IDLE: if (fall) begin st_d = ST_LOW; restart = 1'b1; end
         ST_LOW:  if (rise) begin st_d = ST_HIGH; restart = 1'b1; end
         ST_HIGH: begin
            if (over) begin
               push = 1'b1; tmo_o = 1'b1; st_d = ST_IDLE; restart = 1'b1;
            end else if (fall) begin
               push = 1'b1; st_d = ST_LOW; restart = 1'b1;
            end
         end
         default: st_d = ST_OFF;
      endcase
      if (!run_i) begin
         st_d  = ST_OFF;
         push  = 1'b0;
         tmo_o = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_OFF;
         line_q <= 1'b1;
         pre_q  <= '0;
         dec_q  <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         st_q   <= st_d;
         line_q <= line_i;
         if (restart || tick) begin
            pre_q <= '0;
            dec_q <= '0;
         end else if (pre_q == presc_i) begin
            pre_q <= '0;
            dec_q <= dec_q + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
         if (st_d == ST_LOW && st_q != ST_LOW) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (st_q == ST_LOW && !rise && tick) begin
            lo_q <= sat_inc(lo_q);
         end else if (st_q == ST_LOW && rise) begin
            hi_q <= '0;
         end else if (st_q == ST_HIGH && !over && !fall && tick) begin
            hi_q <= sat_inc(hi_q);
         end
      end
   end

   assign sym_valid_o = push;
   assign sym_lo_o    = lo_q;
   assign sym_hi_o    = hi_q;

   // R6
   tmo_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmo_o && lo_q < max_w_i) |-> (sum == {1'b0, max_w_i}));

   // R3
   off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !sym_valid_o);

endmodule

// File: rtl/irc_sym_fifo.sv
module irc_sym_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 32
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       push_i,
   input  logic [WIDTH-1:0]           wdata_i,
   input  logic                       pop_i,
   output logic [WIDTH-1:0]           rdata_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o,
   output logic                       full_o,
   output logic                       empty_o,
   output logic                       drop_o
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
      $error("DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wr_q, rd_q;
   logic [CW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign do_pop  = pop_i && !empty_o;
   assign do_push = push_i && (!full_o || do_pop);
   assign drop_o  = push_i && !do_push;
   assign rdata_o = empty_o ? '0 : mem_q[rd_q];
   assign count_o = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wr_q] <= wdata_i;
   end

   // R9
   fifo_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && push_i && !pop_i) |=> $stable(count_o));

   // R7
   fifo_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && !push_i && !empty_o) |=> (count_o == $past(count_o) - 1'b1));

endmodule

// File: rtl/irc_raw_capture.sv
module irc_raw_capture
   import irc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned FILT_LEN   = 3,
   parameter int unsigned UNIT_TICKS = 10
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        ir_i,
   input  logic        reg_wr_i,
   input  logic        reg_rd_i,
   input  logic [5:0]  reg_addr_i,
   input  logic [31:0] reg_wdata_i,
   output logic [31:0] reg_rdata_o,
   output logic        irq_o
);

   localparam int unsigned DUR_W  = 16;
   localparam int unsigned CW     = $clog2(FIFO_DEPTH + 1);
   localparam int unsigned SETTLE = FILT_LEN + 3;
   localparam int unsigned SW     = $clog2(SETTLE + 1);

   logic              en_q, run_q;
   cfg_t              cfg_q;
   logic [2:0]        mask_q;
   logic              sts_tmo_q, sts_ovf_q;
   logic [SW-1:0]     settle_q;
   logic              line_f;
   logic              sym_valid, sym_tmo;
   logic [DUR_W-1:0]  sym_lo, sym_hi;
   logic [31:0]       head;
   logic [CW-1:0]     fill;
   logic              fifo_full, fifo_empty, fifo_drop, pop;
   logic              wr_en, wr_clr, wr_start;
   logic              sts_rcv;
   logic [2:0]        raw_sts, msk_sts;

   assign wr_en    = reg_wr_i && reg_addr_i == A_ENABLE;
   assign wr_clr   = reg_wr_i && reg_addr_i == A_CLEAR;
   assign wr_start = reg_wr_i && reg_addr_i == A_START;
   assign pop      = reg_rd_i && reg_addr_i == A_DATA && !fifo_empty;

   irc_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(ir_i), .line_o(line_f)
   );

   irc_sym_meter #(.DUR_W(DUR_W), .PRE_W(7), .UNIT_TICKS(UNIT_TICKS)) u_meter (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .line_i(line_f),
      .presc_i(cfg_q.presc), .max_w_i(cfg_q.max_w),
      .sym_valid_o(sym_valid), .sym_lo_o(sym_lo), .sym_hi_o(sym_hi),
      .tmo_o(sym_tmo)
   );

   irc_sym_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(sym_valid),
      .wdata_i({sym_hi, sym_lo}), .pop_i(pop), .rdata_o(head),
      .count_o(fill), .full_o(fifo_full), .empty_o(fifo_empty),
      .drop_o(fifo_drop)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q      <= 1'b0;
         run_q     <= 1'b0;
         cfg_q     <= CFG_RESET;
         mask_q    <= '0;
         sts_tmo_q <= 1'b0;
         sts_ovf_q <= 1'b0;
         settle_q  <= '0;
      end else begin
         if (wr_en) begin
            en_q     <= reg_wdata_i[0];
            settle_q <= reg_wdata_i[0] ? SW'(SETTLE) : '0;
            if (!reg_wdata_i[0]) run_q <= 1'b0;
         end else if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
         end
         if (wr_start && en_q) run_q <= 1'b1;
         if (reg_wr_i && reg_addr_i == A_CONFIG) cfg_q <= cfg_t'(reg_wdata_i);
         if (reg_wr_i && reg_addr_i == A_MASK)   mask_q <= reg_wdata_i[10:8];
         sts_tmo_q <= (sts_tmo_q & ~(wr_clr & reg_wdata_i[17])) | sym_tmo;
         sts_ovf_q <= (sts_ovf_q & ~(wr_clr & reg_wdata_i[18])) | fifo_drop;
      end
   end

   assign sts_rcv = en_q && (int'(fill) >= int'(cfg_q.lvl_m1) + 1);
   assign raw_sts = {sts_ovf_q, sts_tmo_q, sts_rcv};
   assign msk_sts = raw_sts & ~mask_q;
   assign irq_o   = |msk_sts;

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         A_ENABLE: reg_rdata_o[0]     = en_q;
         A_CONFIG: reg_rdata_o        = cfg_q;
         A_BUSY:   reg_rdata_o[0]     = (settle_q != '0);
         A_COUNT:  reg_rdata_o[CW-1:0] = fill;
         A_DATA:   reg_rdata_o        = head;
         A_MASK:   reg_rdata_o[10:8]  = mask_q;
         A_STATUS: begin
            reg_rdata_o[10:8]  = raw_sts;
            reg_rdata_o[26:24] = msk_sts;
         end
         default:  reg_rdata_o = '0;
      endcase
   end

   // R9
   ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sts_ovf_q) |-> $past(sym_valid && fifo_full && !pop));

   // R2
   busy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && reg_wdata_i[0]) |=> (settle_q != '0));

   // R11
   tmo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_tmo_q && !wr_clr) |=> sts_tmo_q);

endmodule

// File: tb/irc_raw_capture_tb_top.sv
`timescale 1ns/1ps
module irc_raw_capture_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ir = 1'b1;
   logic        wr = 1'b0, rd = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   irc_raw_capture dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ir_i(ir),
      .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   // Reference FIFO model: expected words in order
   logic [31:0] model_q [$];

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk);
      #1 rd = 1'b0;
   endtask

   task automatic send_sym(input int lo_cyc, input int hi_cyc);
      @(negedge clk);
      ir = 1'b0;
      repeat (lo_cyc) @(negedge clk);
      ir = 1'b1;
      repeat (hi_cyc - 1) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] word(input int lo, input int hi);
      return {16'(hi), 16'(lo)};
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd_reg(6'h04, v); check("R1 config", v, 32'h3E80_0080);
      rd_reg(6'h20, v); check("R1 count", v, 32'd0);
      rd_reg(6'h2C, v); check("R1 status", v, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);

      // R2 busy after enable
      wr_reg(6'h00, 32'd1);
      rd_reg(6'h1C, v); check("R2 busy set", v, 32'd1);
      idle(10);
      rd_reg(6'h1C, v); check("R2 busy clear", v, 32'd0);

      // R3 edges before start are ignored
      send_sym(105, 155);
      idle(50);
      rd_reg(6'h20, v); check("R3 no capture before start", v, 32'd0);

      // R4 config readback: max 40, level 3, raw, prescaler 0
      wr_reg(6'h04, 32'h0028_0280);
      rd_reg(6'h04, v); check("R4 config readback", v, 32'h0028_0280);
      wr_reg(6'h28, 32'd0);
      wr_reg(6'h34, 32'h5A);
      idle(20);

      // Three symbols: last one ends by timeout
      send_sym(105, 155); model_q.push_back(word(10, 15));
      send_sym(205, 105); model_q.push_back(word(20, 10));
      send_sym(55, 600);  model_q.push_back(word(5, 35));
      rd_reg(6'h20, v); check("R7 count three", v, 32'd3);
      rd_reg(6'h2C, v); check("R8/R6/R10 status rcv+tmo", v, 32'h0300_0300);
      check("R10 irq high", {31'd0, irq}, 32'd1);
      rd_reg(6'h24, v); check("R4/R5 word one", v, model_q.pop_front());
      rd_reg(6'h24, v); check("R5 word two", v, model_q.pop_front());
      rd_reg(6'h24, v); check("R6 timeout word", v, model_q.pop_front());
      rd_reg(6'h20, v); check("R7 count drained", v, 32'd0);
      rd_reg(6'h2C, v); check("R8 rcv drops below level", v, 32'h0200_0200);
      wr_reg(6'h30, 32'h0002_0000);
      rd_reg(6'h2C, v); check("R11 timeout cleared", v, 32'd0);

      // R10 masking the timeout source
      wr_reg(6'h28, 32'h0000_0200);
      send_sym(105, 600);
      rd_reg(6'h2C, v); check("R10 masked copy hidden", v, 32'h0000_0200);
      check("R10 irq masked", {31'd0, irq}, 32'd0);
      wr_reg(6'h28, 32'd0);
      rd_reg(6'h2C, v); check("R10 unmasked", v, 32'h0200_0200);
      check("R10 irq unmasked", {31'd0, irq}, 32'd1);
      rd_reg(6'h24, v); check("R6 masked-run word", v, word(10, 30));
      wr_reg(6'h30, 32'h0002_0000);

      // R9 overflow: 18 symbols into 16 entries
      for (int i = 0; i < 17; i++) send_sym(25, 25);
      send_sym(25, 600);
      for (int i = 0; i < 16; i++) model_q.push_back(word(2, 2));
      rd_reg(6'h20, v); check("R9 count full", v, 32'd16);
      rd_reg(6'h2C, v); check("R9 status ovf", v, 32'h0700_0700);
      for (int i = 0; i < 16; i++) begin
         rd_reg(6'h24, v); check("R9 kept word", v, model_q.pop_front());
      end
      rd_reg(6'h24, v); check("R7 empty read", v, 32'd0);
      rd_reg(6'h2C, v); check("R9 ovf sticky", v, 32'h0600_0600);
      wr_reg(6'h30, 32'h0006_0000);
      rd_reg(6'h2C, v); check("R11 both cleared", v, 32'd0);

      // R4 prescaler 1: unit is 20 cycles
      wr_reg(6'h04, 32'h0028_0281);
      idle(5);
      send_sym(205, 1000);
      rd_reg(6'h24, v); check("R4 prescaler word", v, word(10, 30));
      wr_reg(6'h30, 32'h0002_0000);

      // R3 disable stops capture, re-enable needs start
      wr_reg(6'h00, 32'd0);
      send_sym(105, 155);
      wr_reg(6'h00, 32'd1);
      send_sym(105, 600);
      rd_reg(6'h20, v); check("R3 no capture after disable", v, 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule